// File: doc/BRIEF.md
# Register-Offset Load/Store Unit

This unit carries out the register-plus-register load and store instructions of a 16-bit compressed instruction set. A start strobe comes with a 16-bit instruction word. If bits 15:12 of that word are 0101, the unit reads a base register and an offset register from its eight-entry register file. It adds the two to form the effective address and runs one memory access on a simple request/ready bus. For a load, the returned data is aligned, rotated or sign-extended, then written back to the destination register. The writeback appears on the writeback port.

The control is a three-state machine:
- IDLE waits for a start strobe that carries a matching instruction (transition IDLE→ACCESS). It captures the effective address and the store data at that moment.
- ACCESS holds the bus request until ready is seen. A store then returns to IDLE (ACCESS→IDLE). A load moves to WRITEBACK (ACCESS→WRITEBACK).
- WRITEBACK writes the register file for one cycle and returns to IDLE (WRITEBACK→IDLE).

Misaligned word loads and zero-extended halfword loads do not fault. They return rotated data.

Top module: `regoff_lsu`

## Requirements
- R1: A start pulse whose instruction bits 15:12 are not 0101 is ignored: busy and the bus request stay low.
- R2: The effective address is the 32-bit sum of the base register (bits 5:3) and the offset register (bits 8:6), with no scaling. The bus address has bits 1:0 cleared for word accesses and bit 0 cleared for halfword accesses. Byte accesses use the address unchanged. The bus address is stable while the request waits for ready.
- R3: With bit 9 clear, operation bits 11:10 select the access. The codes are 00 word store, 01 byte store, 10 word load and 11 zero-extended byte load. A byte load returns the byte on lane address[1:0] of the read data, where lane n is bits 8n+7:8n.
- R4: With bit 9 set, the codes are 00 halfword store, 01 zero-extended halfword load, 10 sign-extended byte load and 11 sign-extended halfword load. The bus size code is 00 for byte, 01 for halfword and 10 for word. The write strobe is high only for stores.
- R5: A word load rotates the 32-bit read data right by 8 × address[1:0] before writeback.
- R6: A zero-extended halfword load takes the halfword on lane address[1] (upper half when 1). It zero-extends that halfword to 32 bits and then rotates it right by 8 × address[0].
- R7: A sign-extended byte load sign-extends lane address[1:0] from bit 7. A sign-extended halfword load sign-extends lane address[1] from bit 15, with no rotation.
- R8: Store write data has the following form. A word store sends the source register (bits 2:0). A byte store repeats its low byte on all four lanes. A halfword store repeats its low halfword on both halves.
- R9: Stores never write back. A load raises the writeback enable for exactly one cycle, in the cycle after the edge that samples ready. It presents the destination index and the formatted data at the same time.
- R10: Busy rises in the cycle after an accepted start. It stays high until the access completes. The bus request is high only in the access state. Start pulses that arrive while busy are ignored.
- R11: After reset, busy, the bus request and the writeback enable are low, and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, sampled in IDLE |
| instr | input | 16 | Instruction word |
| busy | output | 1 | Access in progress |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Write strobe (store) |
| bus_size | output | 2 | 00 byte, 01 halfword, 10 word |
| bus_addr | output | 32 | Aligned bus address |
| bus_wdata | output | 32 | Lane-replicated write data |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Access completes when high with request |
| wb_en | output | 1 | Register writeback enable |
| wb_idx | output | 3 | Writeback register index |
| wb_data | output | 32 | Writeback data |

## Verification
Busy and the bus request appear one cycle after the edge that accepts a start. A store ends with busy low in the cycle after ready is sampled. A load instead shows its writeback one cycle after that edge, and busy falls one cycle later. A behavioural model in the bench advances on each rising edge from the same inputs. The DUT outputs are compared with it on each falling edge, so every result is checked in exactly the cycle it is due. Start pulses are also injected during the access and writeback states to show they are dropped.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ACCESS    = 2'd1,
        ST_WRITEBACK = 2'd2
    } lsu_state_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } bus_size_t;

    // encoding is {extended-group bit, operation code}
    typedef enum logic [2:0] {
        K_ST_W  = 3'd0,
        K_ST_B  = 3'd1,
        K_LD_W  = 3'd2,
        K_LD_BU = 3'd3,
        K_ST_H  = 3'd4,
        K_LD_HU = 3'd5,
        K_LD_BS = 3'd6,
        K_LD_HS = 3'd7
    } mem_kind_t;

    typedef struct packed {
        logic      hit;
        mem_kind_t kind;
        logic [2:0] ro;
        logic [2:0] rb;
        logic [2:0] rd;
    } ldst_fields_t;

    function automatic logic kind_is_load(mem_kind_t k);
        return !(k == K_ST_W || k == K_ST_B || k == K_ST_H);
    endfunction

    function automatic bus_size_t kind_size(mem_kind_t k);
        unique case (k)
            K_ST_W, K_LD_W:           return SZ_WORD;
            K_ST_B, K_LD_BU, K_LD_BS: return SZ_BYTE;
            default:                  return SZ_HALF;
        endcase
    endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [15:0]  instr,
    output ldst_fields_t fld
);
    localparam logic [3:0] CLASS_CODE = 4'b0101;

    always_comb begin
        fld.hit  = (instr[15:12] == CLASS_CODE);
        fld.kind = mem_kind_t'({instr[9], instr[11:10]});
        fld.ro   = instr[8:6];
        fld.rb   = instr[5:3];
        fld.rd   = instr[2:0];
    end
endmodule

// File: rtl/lsu_regfile.sv
module lsu_regfile #(
    parameter int REG_COUNT = 8,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic [IDX_W-1:0]  rd_c_idx,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    output logic [DATA_W-1:0] rd_c,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] regs [REG_COUNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    assign rd_a = regs[rd_a_idx];
    assign rd_b = regs[rd_b_idx];
    assign rd_c = regs[rd_c_idx];
endmodule

// File: rtl/lsu_lanes.sv
module lsu_lanes
    import lsu_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DW   = 8 * LANES
) (
    input  mem_kind_t   kind,
    input  logic [1:0]  addr_lo,
    input  logic [DW-1:0] sdata,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] ldata
);
    logic [DW-1:0] byte_rep;
    logic [DW-1:0] half_rep;
    logic [7:0]    sel_b;
    logic [15:0]   sel_h;
    logic [DW-1:0] half_z;

    for (genvar g = 0; g < LANES; g++) begin : g_brep
        assign byte_rep[8*g +: 8] = sdata[7:0];
    end
    for (genvar g = 0; g < LANES / 2; g++) begin : g_hrep
        assign half_rep[16*g +: 16] = sdata[15:0];
    end

    always_comb begin
        unique case (addr_lo)
            2'd0: sel_b = rdata[7:0];
            2'd1: sel_b = rdata[15:8];
            2'd2: sel_b = rdata[23:16];
            default: sel_b = rdata[31:24];
        endcase
        sel_h  = addr_lo[1] ? rdata[31:16] : rdata[15:0];
        half_z = {16'h0000, sel_h};
    end

    always_comb begin
        wdata = sdata;
        ldata = '0;
        unique case (kind)
            K_ST_W:  wdata = sdata;
            K_ST_B:  wdata = byte_rep;
            K_ST_H:  wdata = half_rep;
            K_LD_W: begin
                unique case (addr_lo)
                    2'd0: ldata = rdata;
                    2'd1: ldata = {rdata[7:0],  rdata[31:8]};
                    2'd2: ldata = {rdata[15:0], rdata[31:16]};
                    default: ldata = {rdata[23:0], rdata[31:24]};
                endcase
            end
            K_LD_BU: ldata = {24'h000000, sel_b};
            K_LD_HU: ldata = addr_lo[0] ? {half_z[7:0], half_z[31:8]} : half_z;
            K_LD_BS: ldata = {{24{sel_b[7]}}, sel_b};
            K_LD_HS: ldata = {{16{sel_h[15]}}, sel_h};
            default: ldata = '0;
        endcase
    end
endmodule

// File: rtl/regoff_lsu.sv
module regoff_lsu
    import lsu_pkg::*;
#(
    parameter int REG_COUNT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] instr,
    output logic        busy,
    output logic        bus_req,
    output logic        bus_we,
    output logic [1:0]  bus_size,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ready,
    output logic        wb_en,
    output logic [2:0]  wb_idx,
    output logic [31:0] wb_data
);
    localparam int DW = 32;

    lsu_state_t   state_q, state_d;
    ldst_fields_t fld;
    mem_kind_t    kind_q;
    logic [2:0]   rd_q;
    logic [DW-1:0] addr_q, sdata_q, wb_q;
    logic [DW-1:0] base_v, off_v, src_v, lane_w, lane_l;
    logic          accept;

    lsu_decode u_dec (.instr(instr), .fld(fld));

    lsu_regfile #(.REG_COUNT(REG_COUNT), .DATA_W(DW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(fld.rb), .rd_b_idx(fld.ro), .rd_c_idx(fld.rd),
        .rd_a(base_v), .rd_b(off_v), .rd_c(src_v),
        .wr_en(wb_en), .wr_idx(rd_q), .wr_data(wb_q)
    );

    lsu_lanes #(.LANES(DW / 8)) u_lanes (
        .kind(kind_q), .addr_lo(addr_q[1:0]),
        .sdata(sdata_q), .rdata(bus_rdata),
        .wdata(lane_w), .ldata(lane_l)
    );

    assign accept = (state_q == ST_IDLE) && start && fld.hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = ST_ACCESS;
            ST_ACCESS:    if (bus_ready) state_d = kind_is_load(kind_q) ? ST_WRITEBACK : ST_IDLE;
            ST_WRITEBACK: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_ST_W;
            rd_q    <= '0;
            addr_q  <= '0;
            sdata_q <= '0;
            wb_q    <= '0;
        end else begin
            if (accept) begin
                kind_q  <= fld.kind;
                rd_q    <= fld.rd;
                addr_q  <= base_v + off_v;
                sdata_q <= src_v;
            end
            if (state_q == ST_ACCESS && bus_ready) wb_q <= lane_l;
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        bus_req   = (state_q == ST_ACCESS);
        bus_we    = bus_req && !kind_is_load(kind_q);
        bus_size  = kind_size(kind_q);
        unique case (kind_size(kind_q))
            SZ_WORD: bus_addr = {addr_q[DW-1:2], 2'b00};
            SZ_HALF: bus_addr = {addr_q[DW-1:1], 1'b0};
            default: bus_addr = addr_q;
        endcase
        bus_wdata = lane_w;
        wb_en     = (state_q == ST_WRITEBACK);
        wb_idx    = rd_q;
        wb_data   = wb_q;
    end

    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && instr[15:12] != 4'b0101) |=> !busy); // R1
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_size == 2'b10) |-> (bus_addr[1:0] == 2'b00)); // R2
    AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_size == 2'b01) |-> !bus_addr[0]); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr))); // R10
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy); // R10
    AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !wb_en); // R9
    AST_WB_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(bus_req && bus_ready && !bus_we)); // R9
endmodule

// File: tb/tb_regoff_lsu.sv
module tb_regoff_lsu;
    logic        clk = 1'b0;
    logic        rst_n, start, bus_ready;
    logic [15:0] instr;
    logic [31:0] bus_rdata;
    logic        busy, bus_req, bus_we, wb_en;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr, bus_wdata, wb_data;
    logic [2:0]  wb_idx;

    int tests = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    regoff_lsu dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .busy(busy), .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_st;
    int          m_kind;
    int          m_rd;
    logic [31:0] m_addr, m_src, m_wb;
    logic [31:0] mregs [8];

    function automatic bit is_ld(int k);
        return !(k == 0 || k == 1 || k == 4);
    endfunction

    function automatic int size_of(int k);
        if (k == 0 || k == 2) return 2;
        if (k == 1 || k == 3 || k == 6) return 0;
        return 1;
    endfunction

    function automatic logic [31:0] rotr(logic [31:0] x, int s);
        logic [63:0] t;
        t = {x, x} >> s;
        return t[31:0];
    endfunction

    function automatic logic [31:0] ld_val(int k, logic [31:0] a, logic [31:0] d);
        logic [31:0] b, h;
        b = (d >> (8 * a[1:0])) & 32'hFF;
        h = (d >> (16 * a[1])) & 32'hFFFF;
        case (k)
            2: return rotr(d, 8 * a[1:0]);
            3: return b;
            5: return rotr(h, 8 * a[0]);
            6: return b[7] ? (b | 32'hFFFF_FF00) : b;
            default: return h[15] ? (h | 32'hFFFF_0000) : h;
        endcase
    endfunction

    function automatic string ld_tag(int k);
        if (k == 2) return "R5";
        if (k == 5) return "R6";
        if (k == 3) return "R3";
        return "R7";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
            for (int i = 0; i < 8; i++) mregs[i] = 32'h0;
        end else begin
            case (m_st)
                0: if (start && instr[15:12] == 4'b0101) begin
                    m_kind = {29'd0, instr[9], instr[11:10]};
                    m_rd   = int'(instr[2:0]);
                    m_addr = mregs[instr[5:3]] + mregs[instr[8:6]];
                    m_src  = mregs[instr[2:0]];
                    m_st   = 1;
                end
                1: if (bus_ready) begin
                    if (is_ld(m_kind)) begin
                        m_wb = ld_val(m_kind, m_addr, bus_rdata);
                        m_st = 2;
                    end else m_st = 0;
                end
                default: begin
                    mregs[m_rd] = m_wb;
                    m_st = 0;
                end
            endcase
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] ea, ew;
            chk(busy == (m_st != 0), "R10 busy", {31'd0, busy}, {31'd0, m_st != 0});
            chk(bus_req == (m_st == 1), "R10 bus_req", {31'd0, bus_req}, {31'd0, m_st == 1});
            chk(wb_en == (m_st == 2), "R9 wb_en", {31'd0, wb_en}, {31'd0, m_st == 2});
            if (m_st == 1) begin
                ea = m_addr;
                if (size_of(m_kind) == 2) ea = m_addr & 32'hFFFF_FFFC;
                if (size_of(m_kind) == 1) ea = m_addr & 32'hFFFF_FFFE;
                chk(bus_addr == ea, "R2 address", bus_addr, ea);
                chk(int'(bus_size) == size_of(m_kind), m_kind < 4 ? "R3 size" : "R4 size",
                    {30'd0, bus_size}, size_of(m_kind));
                chk(bus_we == !is_ld(m_kind), m_kind < 4 ? "R3 write" : "R4 write",
                    {31'd0, bus_we}, {31'd0, !is_ld(m_kind)});
                if (!is_ld(m_kind)) begin
                    ew = m_src;
                    if (m_kind == 1) ew = {4{m_src[7:0]}};
                    if (m_kind == 4) ew = {2{m_src[15:0]}};
                    chk(bus_wdata == ew, "R8 wdata", bus_wdata, ew);
                end
            end
            if (m_st == 2) begin
                chk(int'(wb_idx) == m_rd, "R9 wb_idx", {29'd0, wb_idx}, m_rd);
                chk(wb_data == m_wb, ld_tag(m_kind), wb_data, m_wb);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_op(input logic [15:0] ins, input logic [31:0] rv, input int waits,
                         input bit stray_acc, input bit stray_wb);
        int k;
        k = {29'd0, ins[9], ins[11:10]};
        @(negedge clk); instr = ins; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < waits; i++) begin
            if (stray_acc && i == 0) begin start = 1'b1; instr = 16'h5C3F; end
            @(negedge clk); start = 1'b0;
        end
        bus_ready = 1'b1; bus_rdata = rv;
        @(negedge clk); bus_ready = 1'b0; bus_rdata = 32'hDEAD_0000;
        if (stray_wb && is_ld(k)) begin
            start = 1'b1; instr = 16'h5A12;
            @(negedge clk); start = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(int k, int ro, int rb, int rd);
        return 16'h5000 | 16'((k & 3) << 10) | 16'(((k >> 2) & 1) << 9)
             | 16'(ro << 6) | 16'(rb << 3) | 16'(rd);
    endfunction

    task automatic foreign(input logic [15:0] ins);
        @(negedge clk); instr = ins; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(!busy && !bus_req, "R1 foreign start", {30'd0, busy, bus_req}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; instr = 16'h0; bus_ready = 1'b0; bus_rdata = 32'h0;
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req && !wb_en, "R11 reset outputs", {29'd0, busy, bus_req, wb_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_req && !wb_en, "R11 after release", {29'd0, busy, bus_req, wb_en}, 32'd0);

        foreign(16'h6123);
        foreign(16'h4A5B);

        // R11: a store of an untouched register reads zero (compared by the model)
        do_op(mk(0, 0, 0, 4), 32'h0, 0, 0, 0);

        // preload registers through word loads at address 0
        do_op(mk(2, 0, 0, 1), 32'h0000_0001, 1, 0, 0);
        do_op(mk(2, 0, 0, 2), 32'h0000_0002, 0, 0, 0);
        do_op(mk(2, 0, 0, 3), 32'h0000_0003, 2, 0, 0);
        do_op(mk(2, 0, 0, 5), 32'h0000_0100, 0, 0, 0);
        do_op(mk(2, 0, 0, 4), 32'h8421_F00D, 1, 0, 0);
        do_op(mk(2, 0, 0, 6), 32'hCAFE_BABE, 0, 0, 0);

        for (int k = 0; k < 8; k++) begin
            for (int off = 0; off < 4; off++) begin
                logic [31:0] rv;
                rv = {8'hA0 + 8'(k), 8'h85, 8'h7C ^ 8'(off), 8'hF3};
                do_op(mk(k, off, 5, is_ld(k) ? 7 : ((off & 1) ? 6 : 4)), rv,
                      (k + off) % 4, off == 2, off == 1);
                if (is_ld(k)) do_op(mk(0, 0, 5, 7), 32'h0, 0, 0, 0);
            end
        end

        foreign(16'hF000);
        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule